// File: doc/BRIEF.md
# Signed-Amount Bidirectional Shifter

This block shifts a 64-bit integer source value, treating it either as a 32-bit value held in the low half or as a full 64-bit value. The sign of the shift amount sets the direction. A positive amount shifts left and fills with zeros. A negative amount shifts right arithmetically by its magnitude and fills with copies of the sign bit.

The amount can come from two places. One is a 32-bit signed amount supplied by the host. The other is a 7-bit signed immediate built from two separate fields of a 32-bit instruction word. For immediate shifts, the width comes from an instruction field. For host-amount shifts, the width comes from a select pin.

The result is registered, so it appears one clock after the inputs are presented. Writing the result back to a register file is left to the surrounding logic.

Top module: `sgn_shift_unit`

## Requirements
- R1: With `use_imm`=1 the amount is the 7-bit two's-complement value whose bits 6..4 are `insn[7:5]` and whose bits 3..0 are `insn[3:0]`. Its sign is therefore `insn[7]`, and its range is -64 to +63.
- R2: An immediate amount of zero or more shifts left by that amount. A negative immediate amount shifts right arithmetically by its magnitude.
- R3: With `use_imm`=0 the amount is `host_amt`, read as signed. A strictly positive value shifts left. Zero or a negative value shifts right arithmetically by its magnitude, so zero returns the operand unchanged and -2^31 is handled with its full magnitude.
- R4: With `use_imm`=1, `insn[21:20]` picks the width: 2'b00 selects 32-bit and 2'b10 selects 64-bit. The codes 2'b01 and 2'b11 are not shifts, and the result then equals the source unchanged.
- R5: In 32-bit mode only `src_val[31:0]` is shifted, as a 32-bit value whose sign bit is bit 31. `result[63:32]` equals `src_val[63:32]`.
- R6: In 64-bit mode the whole 64-bit value is shifted, and its sign bit is bit 63.
- R7: When the amount's magnitude is equal to or greater than the operand width (32 or 64), a left shift gives all zeros and a right shift gives all copies of the sign bit.
- R8: With `use_imm`=0, `wide_sel`=1 selects 64-bit mode and `wide_sel`=0 selects 32-bit mode.
- R9: `result` is registered. It reflects the inputs present at the previous rising clock edge, and it reads zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_val | input | 64 | Source operand |
| use_imm | input | 1 | 1: amount from instruction immediate, 0: from host_amt |
| wide_sel | input | 1 | Width for host-amount shifts (1 = 64-bit) |
| host_amt | input | 32 | Signed shift amount from host |
| insn | input | 32 | Instruction word holding immediate and width code |
| result | output | 64 | Registered shift result |

## Verification
Directed cases cover the edges of the immediate range (+63, -64, -1, 0). Together they separate the split-field assembly and sign extension from a plain contiguous field. Host amounts of 0, +1, -1, 2^31-1 and -2^31 separate the strict-positive-is-left rule from an inclusive one and probe magnitude overflow. Magnitudes just below, at and above 32 and 64, with negative and positive operands, tell a zero fill apart from a sign fill and expose a 32-bit lane that leaks into the upper half. Random operands, amounts and width codes, with both amount sources, are then compared against a bench model that shifts one bit at a time.

// File: rtl/sgn_shift_pkg.sv
package sgn_shift_pkg;
  localparam int DATA_W  = 64;
  localparam int HALF_W  = DATA_W / 2;
  localparam int HOST_W  = 32;
  localparam int IMM_W   = 7;
  localparam int MAG_W   = $clog2(DATA_W) + 1;

  typedef enum logic [1:0] {
    WCODE_NARROW = 2'b00,
    WCODE_RSV1   = 2'b01,
    WCODE_WIDE   = 2'b10,
    WCODE_RSV3   = 2'b11
  } wcode_e;

  // Limit a magnitude to DATA_W so that one narrow field covers every
  // out-of-range amount.
  function automatic logic [MAG_W-1:0] clamp_mag(input logic [HOST_W:0] m);
    if (m >= (HOST_W+1)'(DATA_W)) return MAG_W'(DATA_W);
    return m[MAG_W-1:0];
  endfunction

  // Magnitude of a signed HOST_W-bit value, computed in HOST_W+1 bits.
  function automatic logic [HOST_W:0] abs_wide(input logic [HOST_W-1:0] v);
    if (v[HOST_W-1]) return {1'b0, ~v} + 1'b1;
    return {1'b0, v};
  endfunction
endpackage

// File: rtl/sgn_shift_amt.sv
module sgn_shift_amt
  import sgn_shift_pkg::*;
#(
  parameter int P_HOST_W = HOST_W,
  parameter int P_IMM_W  = IMM_W,
  parameter int P_MAG_W  = MAG_W
) (
  input  logic                use_imm,
  input  logic                wide_sel,
  input  logic [P_HOST_W-1:0] host_amt,
  input  logic [P_IMM_W-1:0]  imm_raw,
  input  logic [1:0]          wcode,
  output logic                go_right,
  output logic [P_MAG_W-1:0]  mag,
  output logic                wide,
  output logic                pass_thru
);
  localparam int IMM_SIGN = P_IMM_W - 1;

  logic                imm_neg;
  logic [P_IMM_W-1:0]  imm_abs;
  logic                host_neg;
  logic                host_zero;
  logic [P_HOST_W:0]   host_abs;

  always_comb begin
    imm_neg   = imm_raw[IMM_SIGN];
    imm_abs   = imm_neg ? (~imm_raw + 1'b1) : imm_raw;
    host_neg  = host_amt[P_HOST_W-1];
    host_zero = (host_amt == '0);
    host_abs  = abs_wide(host_amt);

    if (use_imm) begin
      go_right  = imm_neg;
      mag       = clamp_mag((P_HOST_W+1)'(imm_abs));
      wide      = (wcode_e'(wcode) == WCODE_WIDE);
      pass_thru = wcode[0];
    end else begin
      go_right  = host_neg | host_zero;
      mag       = clamp_mag(host_abs);
      wide      = wide_sel;
      pass_thru = 1'b0;
    end
  end
endmodule

// File: rtl/sgn_shift_lane.sv
module sgn_shift_lane #(
  parameter int W     = 32,
  parameter int MAG_W = 7
) (
  input  logic [W-1:0]     x,
  input  logic             go_right,
  input  logic [MAG_W-1:0] mag,
  output logic [W-1:0]     y
);
  logic over;

  always_comb begin
    over = (int'(mag) >= W);
    if (over)
      y = go_right ? {W{x[W-1]}} : '0;
    else if (go_right)
      y = W'($signed(x) >>> mag);
    else
      y = x << mag;
  end
endmodule

// File: rtl/sgn_shift_unit.sv
module sgn_shift_unit
  import sgn_shift_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src_val,
  input  logic              use_imm,
  input  logic              wide_sel,
  input  logic [HOST_W-1:0] host_amt,
  input  logic [31:0]       insn,
  output logic [DATA_W-1:0] result
);
  // Named internal events, observed by the bound checker.
  logic              go_right;
  logic [MAG_W-1:0]  amt_mag;
  logic              wide_mode;
  logic              pass_thru;
  logic              narrow_mode;
  logic [IMM_W-1:0]  imm_raw;
  logic [HALF_W-1:0] lane_lo;
  logic [DATA_W-1:0] lane_full;
  logic [DATA_W-1:0] next_res;

  // Immediate assembled from two non-adjacent fields.
  assign imm_raw = {insn[7:5], insn[3:0]};

  sgn_shift_amt u_amt (
    .use_imm   (use_imm),
    .wide_sel  (wide_sel),
    .host_amt  (host_amt),
    .imm_raw   (imm_raw),
    .wcode     (insn[21:20]),
    .go_right  (go_right),
    .mag       (amt_mag),
    .wide      (wide_mode),
    .pass_thru (pass_thru)
  );

  sgn_shift_lane #(.W(HALF_W), .MAG_W(MAG_W)) u_lane_lo (
    .x        (src_val[HALF_W-1:0]),
    .go_right (go_right),
    .mag      (amt_mag),
    .y        (lane_lo)
  );

  sgn_shift_lane #(.W(DATA_W), .MAG_W(MAG_W)) u_lane_full (
    .x        (src_val),
    .go_right (go_right),
    .mag      (amt_mag),
    .y        (lane_full)
  );

  assign narrow_mode = !pass_thru && !wide_mode;

  always_comb begin
    if (pass_thru)
      next_res = src_val;
    else if (wide_mode)
      next_res = lane_full;
    else
      next_res = {src_val[DATA_W-1:HALF_W], lane_lo};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result <= '0;
    else        result <= next_res;
  end
endmodule

// File: rtl/sgn_shift_chk.sv
module sgn_shift_chk
  import sgn_shift_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] src_val,
  input logic              use_imm,
  input logic [HOST_W-1:0] host_amt,
  input logic [31:0]       insn,
  input logic              go_right,
  input logic [MAG_W-1:0]  amt_mag,
  input logic              wide_mode,
  input logic              pass_thru,
  input logic              narrow_mode,
  input logic [DATA_W-1:0] result
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_imm_sign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (use_imm && insn[7]) |-> go_right);

  assert_host_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_imm && !host_amt[HOST_W-1] && host_amt != '0) |-> !go_right);

  assert_rsv_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(pass_thru)) |-> (result == $past(src_val)));

  assert_upper_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(narrow_mode)) |->
      (result[DATA_W-1:HALF_W] == $past(src_val[DATA_W-1:HALF_W])));

  assert_sign_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(go_right && wide_mode && !pass_thru)) |->
      (result[DATA_W-1] == $past(src_val[DATA_W-1])));

  assert_left_lsb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(!pass_thru && !go_right && amt_mag != '0)) |->
      (result[0] == 1'b0));

  assert_zero_amt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(amt_mag == '0)) |-> (result == $past(src_val)));
endmodule

bind sgn_shift_unit sgn_shift_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_val     (src_val),
  .use_imm     (use_imm),
  .host_amt    (host_amt),
  .insn        (insn),
  .go_right    (go_right),
  .amt_mag     (amt_mag),
  .wide_mode   (wide_mode),
  .pass_thru   (pass_thru),
  .narrow_mode (narrow_mode),
  .result      (result)
);

// File: tb/sgn_shift_unit_tb.sv
`timescale 1ns/1ps
module sgn_shift_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_val = '0;
  logic        use_imm = 1'b0;
  logic        wide_sel = 1'b0;
  logic [31:0] host_amt = '0;
  logic [31:0] insn = '0;
  logic [63:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sgn_shift_unit u_dut (
    .clk(clk), .rst_n(rst_n), .src_val(src_val), .use_imm(use_imm),
    .wide_sel(wide_sel), .host_amt(host_amt), .insn(insn), .result(result)
  );

  // Bench model: shifts one bit per step.
  function automatic logic [63:0] model(input logic [63:0] s, input bit imm,
      input bit ws, input logic [31:0] ha, input logic [31:0] ins);
    longint a;
    bit     wide;
    int     n;
    logic [6:0]  f;
    logic [63:0] v;
    logic [31:0] h;
    if (imm) begin
      f = {ins[7:5], ins[3:0]};
      a = f[6] ? longint'(f) - 128 : longint'(f);
      if (ins[20]) return s;
      wide = ins[21];
    end else begin
      a = longint'($signed(ha));
      wide = ws;
    end
    n = (a < 0) ? ((-a > 100) ? 100 : int'(-a)) : ((a > 100) ? 100 : int'(a));
    if (wide) begin
      v = s;
      for (int i = 0; i < n; i++)
        v = (a > 0 || (imm && a == 0)) ? {v[62:0], 1'b0} : {v[63], v[63:1]};
      return v;
    end
    h = s[31:0];
    for (int i = 0; i < n; i++)
      h = (a > 0) ? {h[30:0], 1'b0} : {h[31], h[31:1]};
    return {s[63:32], h};
  endfunction

  function automatic logic [31:0] mk_insn(input logic [1:0] wc, input int amt,
      input logic [31:0] noise);
    logic [6:0]  f;
    logic [31:0] w;
    f = 7'(amt);
    w = noise;
    w[3:0] = f[3:0];
    w[7:5] = f[6:4];
    w[21:20] = wc;
    return w;
  endfunction

  task automatic run(input logic [63:0] s, input bit imm, input bit ws,
      input logic [31:0] ha, input logic [31:0] ins, input string tag);
    logic [63:0] exp;
    @(negedge clk);
    src_val = s; use_imm = imm; wide_sel = ws; host_amt = ha; insn = ins;
    exp = model(s, imm, ws, ha, ins);
    @(negedge clk);
    n_chk++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, result, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] neg_v;
    logic [63:0] pos_v;
    void'($urandom(32'h1f2e3d4c));
    neg_v = 64'hF123_4567_89AB_CDEF;
    pos_v = 64'h7654_3210_8765_4321;
    src_val = neg_v;
    repeat (3) @(negedge clk);
    n_chk++;
    if (result !== 64'd0) begin
      n_bad++;
      $display("FAIL R9 reset: got %h expected 0", result);
    end
    rst_n = 1'b1;

    // R1/R2/R6 immediate range edges, 64-bit
    run(neg_v, 1, 0, 0, mk_insn(2'b10, 63, 32'h0), "R1 R2 imm +63 wide");
    run(neg_v, 1, 0, 0, mk_insn(2'b10, -64, 32'hFFFF_FFFF), "R1 R7 imm -64 wide");
    run(pos_v, 1, 0, 0, mk_insn(2'b10, -64, 32'h0), "R7 imm -64 pos");
    run(neg_v, 1, 0, 0, mk_insn(2'b10, -1, 32'h0), "R2 R6 imm -1 wide");
    run(neg_v, 1, 0, 0, mk_insn(2'b10, 0, 32'h0), "R2 imm 0");
    run(neg_v, 1, 0, 0, mk_insn(2'b10, 17, 32'hA5A5_0000), "R1 imm +17 wide");
    // R5/R7 narrow lane
    run(neg_v, 1, 0, 0, mk_insn(2'b00, 40, 32'h0), "R5 R7 narrow left 40");
    run(neg_v, 1, 0, 0, mk_insn(2'b00, -40, 32'h0), "R5 R7 narrow right 40");
    run(pos_v, 1, 0, 0, mk_insn(2'b00, -31, 32'h0), "R5 narrow right 31");
    run(neg_v, 1, 0, 0, mk_insn(2'b00, 5, 32'h0), "R5 narrow left 5");
    // R4 reserved width codes
    run(neg_v, 1, 0, 0, mk_insn(2'b01, 9, 32'h0), "R4 code 01 pass");
    run(neg_v, 1, 0, 0, mk_insn(2'b11, -9, 32'h0), "R4 code 11 pass");
    // R3/R8 host amounts
    run(neg_v, 0, 1, 32'd0, 32'h0, "R3 host zero");
    run(neg_v, 0, 1, 32'd1, 32'h0, "R3 host +1");
    run(neg_v, 0, 1, 32'hFFFF_FFFF, 32'h0, "R3 host -1");
    run(neg_v, 0, 1, 32'h7FFF_FFFF, 32'h0, "R3 R7 host max");
    run(neg_v, 0, 1, 32'h8000_0000, 32'h0, "R3 R7 host min");
    run(neg_v, 0, 0, 32'h8000_0000, 32'h0, "R8 R7 host min narrow");
    run(neg_v, 0, 0, 32'd32, 32'h0, "R8 R7 host 32 narrow");
    run(neg_v, 0, 1, 32'd63, 32'h0, "R6 host 63 wide");
    run(neg_v, 0, 1, 32'd64, 32'h0, "R7 host 64 wide");
    run(neg_v, 0, 0, 32'hFFFF_FFE1, 32'h0, "R8 host -31 narrow");

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [63:0] s;
      logic [31:0] ha;
      logic [31:0] ins;
      bit imm;
      s = {$urandom, $urandom};
      imm = $urandom_range(0, 1);
      ha = ($urandom_range(0, 3) == 0) ? $urandom : 32'($urandom_range(0, 160)) - 32'd80;
      ins = $urandom;
      run(s, imm, 1'($urandom_range(0, 1)), ha, ins, imm ? "R1 R4 random imm" : "R3 R8 random host");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule